// File: doc/BRIEF.md
# Multi-Lane Serial Word Boundary and Skew Aligner

This block sits on the receive side of several serial lanes. Each lane delivers one bit per link clock and carries 8-bit words (eight link clocks per word). The lanes have no framing and no idle symbols, so the receiver has to find word boundaries and lane-to-lane alignment by itself. Two properties of the traffic make this possible. The transmitters send a known training word during dedicated intervals. Valid payload never uses the all-zeros or all-ones word.

Each lane has a framer that shifts in bits and cuts a word every eight clocks. While it is searching, the framer compares each word with the training word. On a mismatch it slips its boundary by one bit, and once it sees the training word at the same boundary four times in a row it declares lock. After lock, it counts consecutive forbidden words and gives up lock after sixteen in a row.

Each locked lane then waits for the start of the next training interval and buffers its words from that point on. Once every lane has buffered its first training word, the group emits one word from each lane per step. Words that left the transmitters in the same word period therefore leave the block together.

Top module: `serial_lane_aligner`

## Requirements
- R1: Each lane shifts in bits most-significant bit first and forms one word from every 8 consecutive bits. A lane strobes at most one word every 8 clocks, apart from the extra bit slip.
- R2: While a lane is unlocked, a word that differs from the training word (parameter TRAIN, default 8'hD4) moves the word boundary one bit later. The lane locks on the 4th consecutive training word seen at the same boundary, and not on the 3rd.
- R3: A lane's lock output is high from the clock edge that takes in its 4th consecutive training word until it loses lock.
- R4: While a lane is locked, a word of 8'h00 or 8'hFF is an error and any other word clears the error run. The 16th consecutive error drops the lane to search. A run of 15 leaves it locked.
- R5: A locked lane takes as its alignment marker a training word whose preceding word was not a training word. The lane buffers that word and every later word, in a buffer 4 words deep.
- R6: Once every lane holds a marker, the block pops one word from each lane together whenever all buffers are non-empty. The first output is the marker set, and later outputs follow in word order, one every 8 clocks. Lane i sits at bits [8i+7:8i] of the output.
- R7: While any lane is unlocked, or when a push would overflow a full buffer, every buffer is flushed and every lane's marker is cleared. No output follows until the next training interval in which all lanes are locked.
- R8: Group lock is high only while every lane is locked and every lane holds its marker.
- R9: After reset all lock outputs, the output strobe and the output word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, one bit per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | LANES | Sampled serial bit of each lane |
| lane_lock | output | LANES | Per-lane word lock |
| group_lock | output | 1 | All lanes locked and aligned |
| word_valid | output | 1 | Aligned word set present on word_out |
| word_out | output | 8*LANES | Aligned words, lane i at [8i+7:8i] |

## Verification
The bench builds the block with its defaults: four lanes, a 4-deep buffer, a lock after four training words and a 16-error drop limit. These values keep a complete lock, drop and relock cycle within a few thousand clocks. The four lanes are skewed by 0, 5, 13 and 22 bits. That skew needs almost three words of buffering, mixes bit offsets with whole-word offsets, and makes each lane's search start at a different boundary. Each framer's boundary lands at a fixed bit phase after lock, so the checks at the 3rd/4th training word and at the 15th/16th forbidden word can be timed to the exact clock.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  localparam int WORD_W = 8;

  function automatic logic is_forbidden(input logic [WORD_W-1:0] w);
    return (w == '0) || (w == '1);
  endfunction
endpackage

// File: rtl/lane_framer.sv
module lane_framer
  import aligner_pkg::*;
#(
  parameter logic [WORD_W-1:0] TRAIN = 8'hD4,
  parameter int LOCK_HITS = 4,
  parameter int ERR_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_o,
  output logic              stb_o,
  output logic              mark_o,
  output logic              lock_o
);
  localparam int CW = $clog2(WORD_W);
  localparam int HW = $clog2(LOCK_HITS);
  localparam int EW = $clog2(ERR_LIMIT);

  logic [WORD_W-1:0] sr_q, sr_n, word_q, word_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [HW-1:0]     hits_q, hits_n;
  logic [EW-1:0]     errs_q, errs_n;
  logic              slip_q, slip_n, lock_q, lock_n, prev_q, prev_n;
  logic              stb_q, stb_n, mark_q, mark_n;
  logic              strobe, is_train, is_bad;

  always_comb begin
    sr_n     = {sr_q[WORD_W-2:0], bit_in};
    strobe   = (cnt_q == CW'(WORD_W-1));
    is_train = (sr_n == TRAIN);
    is_bad   = is_forbidden(sr_n);
    cnt_n    = slip_q ? cnt_q : (strobe ? '0 : cnt_q + 1'b1);
    slip_n   = 1'b0;
    hits_n   = hits_q;
    errs_n   = errs_q;
    lock_n   = lock_q;
    prev_n   = prev_q;
    word_n   = word_q;
    stb_n    = 1'b0;
    mark_n   = 1'b0;
    if (strobe) begin
      if (!lock_q) begin
        if (is_train) begin
          if (hits_q == HW'(LOCK_HITS-1)) begin
            lock_n = 1'b1;
            hits_n = '0;
            errs_n = '0;
            prev_n = 1'b1;
          end else begin
            hits_n = hits_q + 1'b1;
          end
        end else begin
          hits_n = '0;
          slip_n = 1'b1;
        end
      end else begin
        word_n = sr_n;
        stb_n  = 1'b1;
        mark_n = is_train && !prev_q;
        prev_n = is_train;
        if (is_bad) begin
          if (errs_q == EW'(ERR_LIMIT-1)) begin
            lock_n = 1'b0;
            errs_n = '0;
            hits_n = '0;
          end else begin
            errs_n = errs_q + 1'b1;
          end
        end else begin
          errs_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      slip_q <= 1'b0;
      hits_q <= '0;
      errs_q <= '0;
      lock_q <= 1'b0;
      prev_q <= 1'b0;
      word_q <= '0;
      stb_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      sr_q   <= sr_n;
      cnt_q  <= cnt_n;
      slip_q <= slip_n;
      hits_q <= hits_n;
      errs_q <= errs_n;
      lock_q <= lock_n;
      prev_q <= prev_n;
      stb_q  <= stb_n;
      mark_q <= mark_n;
      if (strobe) word_q <= word_n;
    end
  end

  assign word_o = word_q;
  assign stb_o  = stb_q;
  assign mark_o = mark_q;
  assign lock_o = lock_q;

  assert_strobe_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  assert_lock_on_train_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(sr_n == TRAIN));
  assert_drop_on_forbidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(is_bad));
  assert_marker_with_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |-> (stb_q && word_q == TRAIN));
endmodule

// File: rtl/skew_buffer.sv
module skew_buffer
  import aligner_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp_q, wp_n, rp_q, rp_n;
  logic [NW-1:0]     n_q, n_n;
  logic              do_push, do_pop;

  always_comb begin
    do_push = push && !flush;
    do_pop  = pop && !flush && (n_q != '0);
    wp_n    = wp_q;
    rp_n    = rp_q;
    n_n     = n_q;
    if (flush) begin
      wp_n = '0;
      rp_n = '0;
      n_n  = '0;
    end else begin
      if (do_push) wp_n = (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_n = (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      n_n = n_q + NW'(do_push) - NW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      n_q  <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
      n_q  <= n_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (n_q == '0);
  assign full  = (n_q == NW'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |-> flush);
endmodule

// File: rtl/serial_lane_aligner.sv
module serial_lane_aligner
  import aligner_pkg::*;
#(
  parameter int LANES = 4,
  parameter logic [WORD_W-1:0] TRAIN = 8'hD4,
  parameter int LOCK_HITS = 4,
  parameter int ERR_LIMIT = 16,
  parameter int DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        ser_in,
  output logic [LANES-1:0]        lane_lock,
  output logic                    group_lock,
  output logic                    word_valid,
  output logic [LANES*WORD_W-1:0] word_out
);
  logic [LANES-1:0]        stb, mark, lock, empty, full, push;
  logic [LANES-1:0]        marked_q, marked_n;
  logic [LANES*WORD_W-1:0] lane_word, head, out_q;
  logic                    pop, flush, overflow, any_unlocked, valid_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_framer #(.TRAIN(TRAIN), .LOCK_HITS(LOCK_HITS), .ERR_LIMIT(ERR_LIMIT)) u_framer (
      .clk(clk), .rst_n(rst_n), .bit_in(ser_in[i]),
      .word_o(lane_word[i*WORD_W +: WORD_W]), .stb_o(stb[i]),
      .mark_o(mark[i]), .lock_o(lock[i]));

    skew_buffer #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push[i]),
      .din(lane_word[i*WORD_W +: WORD_W]), .pop(pop),
      .dout(head[i*WORD_W +: WORD_W]), .empty(empty[i]), .full(full[i]));
  end

  always_comb begin
    any_unlocked = !(&lock);
    push         = stb & (marked_q | mark);
    pop          = (&marked_q) && !(|empty) && !any_unlocked;
    overflow     = |(push & full) && !pop;
    flush        = any_unlocked || overflow;
    marked_n     = flush ? '0 : (marked_q | (stb & mark));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marked_q <= '0;
      valid_q  <= 1'b0;
      out_q    <= '0;
    end else begin
      marked_q <= marked_n;
      valid_q  <= pop;
      if (pop) out_q <= head;
    end
  end

  assign lane_lock  = lock;
  assign group_lock = (&lock) && (&marked_q);
  assign word_valid = valid_q;
  assign word_out   = out_q;

  assert_output_needs_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(&lock));
  assert_unlock_clears_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&lock) |=> !group_lock);
endmodule

// File: tb/sim_serial_lane_aligner.sv
module sim_serial_lane_aligner;
  localparam int LANES = 4;
  localparam logic [7:0] TRAIN = 8'hD4;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [LANES-1:0]     ser_in;
  logic [LANES-1:0]     lane_lock;
  logic                 group_lock, word_valid;
  logic [LANES*8-1:0]   word_out;

  int tests = 0, fails = 0;
  int t = 0;
  logic run = 1'b0;

  always #10 clk = ~clk;

  serial_lane_aligner u0 (.clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .lane_lock(lane_lock), .group_lock(group_lock),
    .word_valid(word_valid), .word_out(word_out));

  function automatic int lane_delay(input int lane);
    case (lane)
      0: return 0;
      1: return 5;
      2: return 13;
      default: return 22;
    endcase
  endfunction

  function automatic logic [7:0] word_of(input int lane, input int k);
    if (k < 20) return TRAIN;
    if (k >= 60 && k < 66) return TRAIN;
    if (k >= 200 && k < 220) return TRAIN;
    if (k >= 240 && k < 246) return TRAIN;
    if (lane == 2 && ((k >= 120 && k < 135) || (k >= 136 && k < 151))) return 8'h00;
    if (lane == 2 && k >= 170 && k < 186) return 8'hFF;
    return 8'((((k * 5) + (lane * 3)) % 180) + 16);
  endfunction

  function automatic logic stream_bit(input int lane, input int s);
    logic [7:0] w;
    if (s < 0) return 1'b0;
    w = word_of(lane, s / 8);
    return w[7 - (s % 8)];
  endfunction

  always @(negedge clk) begin
    if (run) begin
      for (int i = 0; i < LANES; i++) ser_in[i] <= stream_bit(i, t - lane_delay(i));
      t = t + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic wait_t(input int n);
    while (t < n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic t_reset;
    check(lane_lock == '0, "R9 lane_lock", lane_lock, 0);
    check(group_lock == 1'b0, "R9 group_lock", group_lock, 0);
    check(word_valid == 1'b0, "R9 word_valid", word_valid, 0);
    check(word_out == '0, "R9 word_out", word_out, 0);
  endtask

  task automatic t_lock;
    wait_t(31);
    check(lane_lock[0] == 1'b0, "R2 no lock after 3 training words", lane_lock[0], 0);
    wait_t(32);
    check(lane_lock[0] == 1'b1, "R3 lock on 4th training word", lane_lock[0], 1);
    wait_t(8 * 30);
    check(lane_lock == '1, "R2 all skewed lanes locked", lane_lock, 4'hF);
    check(group_lock == 1'b0, "R8 no group lock before marker", group_lock, 0);
    check(word_valid == 1'b0, "R5 no output before marker", word_valid, 0);
  endtask

  task automatic collect(input int first_k, input int count, input string req);
    int k = first_k;
    int last = -1;
    int guard = 0;
    while (k < first_k + count && guard < 4000) begin
      @(posedge clk);
      #2;
      guard++;
      if (word_valid) begin
        logic [LANES*8-1:0] exp;
        for (int i = 0; i < LANES; i++) exp[i*8 +: 8] = word_of(i, k);
        check(word_out == exp, req, word_out, exp);
        if (last >= 0) check(t - last == 8, "R6 output spacing", t - last, 8);
        check(group_lock == 1'b1, "R8 group lock while aligned", group_lock, 1);
        last = t;
        k++;
      end
    end
    check(k == first_k + count, "R6 output count", k - first_k, count);
  endtask

  task automatic t_align;
    collect(60, 30, "R6 aligned word set");
  endtask

  task automatic t_err_hold;
    wait_t(8 * 160);
    check(lane_lock[2] == 1'b1, "R4 15 forbidden words keep lock", lane_lock[2], 1);
    check(group_lock == 1'b1, "R4 group kept through errors", group_lock, 1);
  endtask

  task automatic t_err_drop;
    wait_t(1496);
    check(lane_lock[2] == 1'b1, "R4 still locked after 15th 0xFF", lane_lock[2], 1);
    wait_t(1502);
    check(lane_lock[2] == 1'b0, "R4 unlock on 16th 0xFF", lane_lock[2], 0);
    check(lane_lock[0] && lane_lock[1] && lane_lock[3], "R4 other lanes unaffected", lane_lock, 4'hB);
    wait_t(1504);
    check(group_lock == 1'b0, "R7 group lock drops", group_lock, 0);
  endtask

  task automatic t_realign;
    int seen = 0;
    while (t < 8 * 238) begin
      @(posedge clk);
      #2;
      if (word_valid) seen++;
    end
    check(seen == 0, "R7 no output until realigned", seen, 0);
    check(lane_lock == '1, "R2 lane relocks on training", lane_lock, 4'hF);
    check(group_lock == 1'b0, "R7 marker cleared until next interval", group_lock, 0);
    collect(240, 12, "R7 realigned word set");
  endtask

  initial begin
    rst_n  = 1'b0;
    ser_in = '0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(posedge clk);
    #5;
    rst_n = 1'b1;
    run   = 1'b1;
    t_lock();
    t_align();
    t_err_hold();
    t_err_drop();
    t_realign();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", t);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule